// File: doc/BRIEF.md
# Wide-Result Multiply-Accumulate Unit

This execution unit serves two instructions with three inputs and two outputs. It multiplies two 64-bit operands A and B into their full unsigned 128-bit product. It then adds that product to a third operand C, or subtracts the product from C. C is widened with zeros to 128 bits first. The 128-bit outcome is split into two results: the low half is written to the RT destination and the high half to a second destination, RS. Because the high half is kept, a loop over the limbs of a long number can feed each high half back in as the next C, like a carry word.

The unit reads the operation from the instruction word itself. It accepts one operation per cycle through a valid/ready handshake and passes it through a multiplier pipeline of fixed, parameterised depth. It returns the results in the order the operations were accepted, through a second valid/ready handshake. Instructions that it does not implement are not executed: they come out in their turn, flagged illegal, with no result data.

Top module: `wide_mac_unit`

## Requirements
- R1: With the add form, {out_rs, out_rt} equals the 128-bit sum of zero-extended in_c and the unsigned product in_a * in_b, taken modulo 2^128 (out_rs is the upper 64 bits).
- R2: With the subtract form, {out_rs, out_rt} equals zero-extended in_c minus the unsigned product in_a * in_b, taken modulo 2^128.
- R3: in_c is never sign-extended: a C with bit 63 set and a zero product gives out_rs = 0 and out_rt = in_c, and a subtract of 1 from C = 0 gives all ones in both halves.
- R4: Bits are numbered MSB-first, so bit 0 is in_instr[31]. The extended opcode is instr[5:0] and the primary opcode is instr[31:26]. Extended opcode 6'b110010 selects add and 6'b110110 selects subtract. The primary opcode must equal parameter MAJOR_OP, which defaults to 4.
- R5: Any other extended opcode, or a different primary opcode, makes the result come out with out_illegal = 1 and with out_rt = out_rs = 0. Legal results have out_illegal = 0.
- R6: in_ready is high exactly when the output register is empty or is being taken (out_ready high). An operation is accepted only on an edge where in_valid and in_ready are both high.
- R7: While out_valid is high and out_ready is low, out_valid, out_rt, out_rs, out_illegal and out_regs hold their values.
- R8: With out_ready held high, an operation accepted on one clock edge shows out_valid high after exactly LATENCY further edges. Results leave in the order they were accepted.
- R9: out_regs carries the four register-number fields instr[25:6] of the instruction that produced the result, in the order {RT, RA, RB, RC}.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_instr | input | 32 | Instruction word |
| in_a | input | 64 | Multiplicand A |
| in_b | input | 64 | Multiplier B |
| in_c | input | 64 | Addend / minuend C, zero-extended |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_rt | output | 64 | Low half of the 128-bit result |
| out_rs | output | 64 | High half of the 128-bit result |
| out_illegal | output | 1 | Instruction not implemented; no results |
| out_regs | output | 20 | Register fields {RT, RA, RB, RC} echoed |

## Verification
The arithmetic is tried with small operands, which tell add from subtract, and with all-ones operands, which force a carry into the high half. A product larger than C makes the subtract wrap around, which shows whether the subtract keeps 128 bits. C with bit 63 set and a zero product shows whether C is sign-extended. Reserved and foreign extended opcodes and a wrong primary opcode check the illegal path. A stream of mixed operations runs with out_ready toggling, which separates correct ordering and holding of results from dropped or duplicated results. A single operation into an idle unit measures the pipeline depth.

// File: rtl/wmac_pkg.sv
// Package: opcode constants shared by the wide multiply-accumulate unit.
// Assumes MSB-first field numbering folded onto a [31:0] vector.
package wmac_pkg;
    localparam int unsigned INSTR_W  = 32;
    localparam int unsigned REGF_W   = 20;
    localparam logic [5:0]  XO_ADD   = 6'b110010;
    localparam logic [5:0]  XO_SUB   = 6'b110110;
endpackage

// File: rtl/wmac_decode.sv
// Module: instruction decoder. Pulls out the extended and primary opcodes
// and sorts the word into add, subtract or illegal. Purely combinational.
module wmac_decode
    import wmac_pkg::*;
#(
    parameter logic [5:0] MAJOR_OP = 6'd4
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               dec_sub,
    output logic               dec_illegal,
    output logic [REGF_W-1:0]  dec_regs
);
    logic [5:0] xo;
    logic [5:0] major;

    // Purpose: slice fields and classify the operation.
    always_comb begin
        xo          = instr[5:0];
        major       = instr[31:26];
        dec_regs    = instr[25:6];
        dec_sub     = (xo == XO_SUB);
        dec_illegal = (major != MAJOR_OP) || !((xo == XO_ADD) || (xo == XO_SUB));
    end
endmodule

// File: rtl/wmac_mul_pipe.sv
// Module: fixed-latency multiplier pipeline. Stage 0 registers the full
// unsigned 2*XLEN product; the remaining stages only delay it together with
// the side data. The whole pipe moves only when adv is high. Assumes LATENCY >= 1.
module wmac_mul_pipe
    import wmac_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_fire,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [XLEN-1:0]   c,
    input  logic              sub,
    input  logic              illegal,
    input  logic [REGF_W-1:0] regs,
    output logic              last_valid,
    output logic [2*XLEN-1:0] last_prod,
    output logic [XLEN-1:0]   last_c,
    output logic              last_sub,
    output logic              last_illegal,
    output logic [REGF_W-1:0] last_regs
);
    localparam int unsigned PW = 2 * XLEN;

    for (genvar s = 0; s < LATENCY; s++) begin : g_stg
        logic              v;
        logic [PW-1:0]     prod;
        logic [XLEN-1:0]   cv;
        logic              sb;
        logic              ill;
        logic [REGF_W-1:0] rg;

        if (s == 0) begin : g_first
            // Purpose: track occupancy of the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n)   v <= 1'b0;
                else if (adv) v <= in_fire;
            end
            // Purpose: form the full-width product and capture side data.
            always_ff @(posedge clk) begin
                if (adv) begin
                    prod <= {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
                    cv   <= c;
                    sb   <= sub;
                    ill  <= illegal;
                    rg   <= regs;
                end
            end
        end else begin : g_delay
            // Purpose: pass occupancy down the pipe.
            always_ff @(posedge clk) begin
                if (!rst_n)   v <= 1'b0;
                else if (adv) v <= g_stg[s-1].v;
            end
            // Purpose: delay product and side data by one stage.
            always_ff @(posedge clk) begin
                if (adv) begin
                    prod <= g_stg[s-1].prod;
                    cv   <= g_stg[s-1].cv;
                    sb   <= g_stg[s-1].sb;
                    ill  <= g_stg[s-1].ill;
                    rg   <= g_stg[s-1].rg;
                end
            end
        end
    end

    assign last_valid   = g_stg[LATENCY-1].v;
    assign last_prod    = g_stg[LATENCY-1].prod;
    assign last_c       = g_stg[LATENCY-1].cv;
    assign last_sub     = g_stg[LATENCY-1].sb;
    assign last_illegal = g_stg[LATENCY-1].ill;
    assign last_regs    = g_stg[LATENCY-1].rg;

    // R6: an accepted operation occupies stage 0 on the next cycle.
    p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> g_stg[0].v);
endmodule

// File: rtl/wmac_combine.sv
// Module: final add/subtract with zero-extended C and the output holding
// register. Produces the pipeline advance enable from the output handshake.
module wmac_combine
    import wmac_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_valid,
    input  logic [2*XLEN-1:0] last_prod,
    input  logic [XLEN-1:0]   last_c,
    input  logic              last_sub,
    input  logic              last_illegal,
    input  logic [REGF_W-1:0] last_regs,
    input  logic              out_ready,
    output logic              adv,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_rt,
    output logic [XLEN-1:0]   out_rs,
    output logic              out_illegal,
    output logic [REGF_W-1:0] out_regs
);
    localparam int unsigned PW = 2 * XLEN;

    logic [PW-1:0] c_ext;
    logic [PW-1:0] res;

    // Purpose: widen C with zeros and apply the selected operation.
    always_comb begin
        c_ext = {{XLEN{1'b0}}, last_c};
        if (last_illegal)  res = '0;
        else if (last_sub) res = c_ext - last_prod;
        else               res = c_ext + last_prod;
    end

    assign adv = !out_valid || out_ready;

    // Purpose: output valid flag, loaded whenever the register may be replaced.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_valid <= 1'b0;
        else if (adv) out_valid <= last_valid;
    end

    // Purpose: output data, split into low (RT) and high (RS) halves.
    always_ff @(posedge clk) begin
        if (adv) begin
            out_rt      <= res[XLEN-1:0];
            out_rs      <= res[PW-1:XLEN];
            out_illegal <= last_illegal;
            out_regs    <= last_regs;
        end
    end

    // R7: a stalled result holds all fields.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rt) && $stable(out_rs)
                                       && $stable(out_illegal) && $stable(out_regs)));
    // R5: an illegal result carries no data.
    p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_rt == '0 && out_rs == '0));
    // R8: a filled last stage moves into the output register when the pipe advances.
    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_valid && adv) |=> out_valid);
endmodule

// File: rtl/wide_mac_unit.sv
// Module: top of the wide multiply-accumulate unit. Decodes the instruction,
// runs the multiplier pipeline and forms the 2*XLEN add/subtract result.
// Assumes one global advance: the pipe stalls as a whole on output backpressure.
module wide_mac_unit
    import wmac_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned LATENCY  = 3,
    parameter logic [5:0]  MAJOR_OP = 6'd4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [INSTR_W-1:0]  in_instr,
    input  logic [XLEN-1:0]     in_a,
    input  logic [XLEN-1:0]     in_b,
    input  logic [XLEN-1:0]     in_c,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [XLEN-1:0]     out_rt,
    output logic [XLEN-1:0]     out_rs,
    output logic                out_illegal,
    output logic [REGF_W-1:0]   out_regs
);
    logic              dec_sub, dec_illegal;
    logic [REGF_W-1:0] dec_regs;
    logic              adv, in_fire;
    logic              last_valid, last_sub, last_illegal;
    logic [2*XLEN-1:0] last_prod;
    logic [XLEN-1:0]   last_c;
    logic [REGF_W-1:0] last_regs;

    assign in_ready = adv;
    assign in_fire  = in_valid && adv;

    wmac_decode #(.MAJOR_OP(MAJOR_OP)) u_dec (
        .instr(in_instr), .dec_sub(dec_sub), .dec_illegal(dec_illegal), .dec_regs(dec_regs)
    );

    wmac_mul_pipe #(.XLEN(XLEN), .LATENCY(LATENCY)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_fire(in_fire),
        .a(in_a), .b(in_b), .c(in_c), .sub(dec_sub), .illegal(dec_illegal), .regs(dec_regs),
        .last_valid(last_valid), .last_prod(last_prod), .last_c(last_c),
        .last_sub(last_sub), .last_illegal(last_illegal), .last_regs(last_regs)
    );

    wmac_combine #(.XLEN(XLEN)) u_comb (
        .clk(clk), .rst_n(rst_n), .last_valid(last_valid), .last_prod(last_prod),
        .last_c(last_c), .last_sub(last_sub), .last_illegal(last_illegal),
        .last_regs(last_regs), .out_ready(out_ready), .adv(adv),
        .out_valid(out_valid), .out_rt(out_rt), .out_rs(out_rs),
        .out_illegal(out_illegal), .out_regs(out_regs)
    );

    // R6: no acceptance while a stalled result occupies the output.
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tb_wide_mac_unit.sv
`timescale 1ns/1ps
module tb_wide_mac_unit;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic [63:0] in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_rt, out_rs;
    logic        out_illegal;
    logic [19:0] out_regs;

    int checks = 0;
    int errors = 0;
    int stall_mode = 0;
    int cyc = 0;

    typedef struct {
        logic [63:0] rt;
        logic [63:0] rs;
        logic        ill;
        logic [19:0] regs;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    wide_mac_unit #(.XLEN(64), .LATENCY(LAT), .MAJOR_OP(6'd4)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_rt(out_rt), .out_rs(out_rs),
        .out_illegal(out_illegal), .out_regs(out_regs)
    );

    function automatic logic [31:0] mk(logic [5:0] maj, logic [4:0] rt, logic [4:0] ra,
                                       logic [4:0] rb, logic [4:0] rc, logic [5:0] xo);
        return {maj, rt, ra, rb, rc, xo};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // out_ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        cyc++;
        #2;
        if (stall_mode != 0) out_ready = (cyc % 3) != 0;
        else                 out_ready = 1'b1;
    end

    // Monitor: compares each transferred result and checks holding under stall
    logic        pv = 1'b0, pr = 1'b1;
    logic [63:0] prt, prs;
    logic        pill;
    logic [19:0] preg;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pr) begin
                chk(out_valid && out_rt == prt && out_rs == prs && out_illegal == pill
                    && out_regs == preg, "R7", "held result",
                    {out_rs, out_rt}, {prs, prt});
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R8", "unexpected result", {out_rs, out_rt}, '0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk({out_rs, out_rt} == {e.rs, e.rt}, e.tag, "rs:rt",
                        {out_rs, out_rt}, {e.rs, e.rt});
                    chk(out_illegal == e.ill, "R5", "illegal flag",
                        128'(out_illegal), 128'(e.ill));
                    chk(out_regs == e.regs, "R9", "register fields",
                        128'(out_regs), 128'(e.regs));
                end
            end
            pv = out_valid; pr = out_ready;
            prt = out_rt; prs = out_rs; pill = out_illegal; preg = out_regs;
        end
    end

    task automatic send(logic [31:0] ins, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                        int kind, string tag);
        exp_t e;
        logic [127:0] p, ce;
        @(negedge clk);
        in_instr = ins; in_a = a; in_b = b; in_c = c; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        p  = {64'd0, a} * {64'd0, b};
        ce = {64'd0, c};
        case (kind)
            0:       {e.rs, e.rt} = ce + p;
            1:       {e.rs, e.rt} = ce - p;
            default: {e.rs, e.rt} = '0;
        endcase
        e.ill = (kind == 2);
        e.regs = ins[25:6];
        e.tag = tag;
        expq.push_back(e);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (expq.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(expq.size() == 0, "R8", "all results delivered", 128'(expq.size()), 0);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [5:0] ADD = 6'b110010;
    localparam logic [5:0] SUB = 6'b110110;

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", 128'(out_valid), 0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", 128'(in_ready), 1);
    endtask

    task automatic t_add();
        send(mk(4, 1, 2, 3, 4, ADD), 64'd7, 64'd6, 64'd100, 0, "R1");
        send(mk(4, 5, 6, 7, 8, ADD), '1, '1, '1, 0, "R1");
        send(mk(4, 9, 10, 11, 12, ADD), 64'h1_0000_0000, 64'h1_0000_0000, 64'd3, 0, "R1");
        send(mk(4, 31, 0, 31, 0, ADD), 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
             64'h8000_0000_0000_0001, 0, "R1");
        drain();
    endtask

    task automatic t_sub();
        send(mk(4, 1, 1, 1, 1, SUB), 64'd5, 64'd4, 64'd50, 1, "R2");
        send(mk(4, 2, 2, 2, 2, SUB), 64'd5, 64'd4, 64'd3, 1, "R2");
        send(mk(4, 3, 3, 3, 3, SUB), '1, '1, 64'd0, 1, "R2");
        send(mk(4, 4, 4, 4, 4, SUB), 64'd0, 64'd0, 64'd0, 1, "R2");
        drain();
    endtask

    task automatic t_zext();
        send(mk(4, 1, 2, 3, 4, ADD), 64'd0, 64'd9, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3");
        send(mk(4, 1, 2, 3, 4, SUB), 64'd1, 64'd1, 64'd0, 1, "R3");
        send(mk(4, 1, 2, 3, 4, ADD), 64'd2, 64'd3, 64'h8000_0000_0000_0000, 0, "R3");
        drain();
    endtask

    task automatic t_illegal();
        send(mk(4, 1, 2, 3, 4, 6'b110000), 64'd3, 64'd3, 64'd3, 2, "R5");
        send(mk(4, 1, 2, 3, 4, 6'b110100), 64'd3, 64'd3, 64'd3, 2, "R5");
        send(mk(4, 1, 2, 3, 4, 6'b110111), 64'd3, 64'd3, 64'd3, 2, "R5");
        send(mk(4, 1, 2, 3, 4, 6'b110011), 64'd3, 64'd3, 64'd3, 2, "R5");
        send(mk(5, 1, 2, 3, 4, ADD), 64'd3, 64'd3, 64'd3, 2, "R4");
        send(mk(4, 7, 7, 7, 7, SUB), 64'd3, 64'd3, 64'd3, 1, "R4");
        drain();
    endtask

    task automatic t_stream();
        logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
        stall_mode = 1;
        for (int i = 0; i < 24; i++) begin
            x = {x[62:0], x[63] ^ x[61] ^ x[60] ^ x[58]} ^ 64'(i);
            send(mk(4, 5'(i), 5'(i + 1), 5'(i + 2), 5'(i + 3), (i % 3 == 0) ? SUB : ADD),
                 x, ~x, x ^ 64'hFFFF, (i % 3 == 0) ? 1 : 0, "R6");
        end
        drain();
        stall_mode = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_latency();
        int n = 0;
        send(mk(4, 1, 2, 3, 4, ADD), 64'd2, 64'd2, 64'd2, 0, "R8");
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        // n negedges: the k-th one shows the state after accepting edge + (k-1)
        chk((n - 1) == LAT, "R8", "edges from accept to out_valid", 128'(n - 1), 128'(LAT));
        drain();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_zext();
        t_illegal();
        t_stream();
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule